// File: doc/BRIEF.md
# Segment Address Translator with Limit and Permission Check

This block turns a logical offset into a physical address through a set of six segment registers. The kind of access picks the segment. An instruction fetch always goes through the code segment. A stack push or pop always goes through the stack segment. Any other data access goes through the data segment, unless a per-request override names one of the other segments. Two of the six segments are reached only through that override.

In the unprotected mode the segment value, shifted left by four bits, is the base. No check is made. In the protected mode the segment value is a selector into an eight-entry descriptor table. Each entry holds a base, a limit, read, write and execute rights, and a valid flag. The access is checked against that entry before the base is added, and a check that fails returns a fault code in place of the address.

One write port loads both the segment registers and the descriptor entries. Each request gives a response one clock later.

Top module: `segx_unit`

## Requirements
- R1: During and right after a synchronous reset, `rsp_valid`, `rsp_fault` and `rsp_addr` are all zero. Reset also sets every segment register to zero and marks every descriptor invalid.
- R2: A request taken on a clock edge produces `rsp_valid`=1 in the following cycle. A cycle with no request produces `rsp_valid`=0, with `rsp_fault` and `rsp_addr` both zero.
- R3: Segment numbering is code=0, stack=1, data=2, extra=3, free A=4, free B=5. The `req_op` encoding is read=0, write=1, fetch=2, and 3 is treated as read. A fetch uses segment 0. A read or write with `req_stack`=1 uses segment 1. Any other access uses segment 2.
- R4: When `req_ovr_en`=1, a non-stack read or write uses segment `req_ovr_seg` if that value is 0 to 5, and segment 2 if it is 6 or 7. The override has no effect on fetches or on stack accesses.
- R5: With `prot_en`=0, the address is (segment value << 4) + offset, taken modulo 2^PA_W, and the fault is always 0 (none). Distinct segment and offset pairs may therefore give the same address.
- R6: With `prot_en`=1 and an access that passes every check, the address is the descriptor base plus the offset, modulo 2^PA_W, and the fault is 0.
- R7: In protected mode, an offset strictly greater than the descriptor limit gives fault 1 (limit) with address 0. An offset equal to the limit is allowed.
- R8: In protected mode, a read needs the r right, a write needs the w right and a fetch needs the x right. A missing right gives fault 2 (permission) with address 0.
- R9: In protected mode, a selector of 8 or more, or a selector that names an entry whose valid flag is clear, gives fault 3 (bad index) with address 0. The faults rank as follows: bad index first, then limit, then permission.
- R10: With `wr_en`=1 and `wr_sel`=0, segment `wr_idx` (0 to 5) takes `wr_data[15:0]`. With `wr_sel`=1, descriptor `wr_idx` takes the following fields: base in bits [31:0], limit in bits [63:32], r in bit 64, w in bit 65, x in bit 66, valid in bit 67. A request in the same cycle as a write sees the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| prot_en | input | 1 | 1 selects protected mode, 0 selects unprotected mode |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | Access type: 0 read, 1 write, 2 fetch, 3 read |
| req_stack | input | 1 | Access is a stack push or pop |
| req_ovr_en | input | 1 | Use the segment override |
| req_ovr_seg | input | 3 | Overriding segment number |
| req_offset | input | OFF_W (32) | Logical offset |
| wr_en | input | 1 | Write strobe for the tables |
| wr_sel | input | 1 | 0 writes a segment register, 1 writes a descriptor |
| wr_idx | input | IDX_W (3) | Entry number to write |
| wr_data | input | DW (68) | Segment value or packed descriptor |
| rsp_valid | output | 1 | Response present |
| rsp_fault | output | 2 | 0 none, 1 limit, 2 permission, 3 bad index |
| rsp_addr | output | PA_W (32) | Physical address, zero when faulted |

## Verification
The bench goes after the edges of each check. An offset exactly at the limit must pass and one past it must fail. An off-by-one comparator would either reject the last legal byte or let one byte through. An access that breaks both the limit and the permission must report the limit fault, and a design with the wrong ranking reports permission instead. The bench also drives overrides on fetch and stack accesses and uses the out-of-range override values 6 and 7. A selector logic that honours the override everywhere would then send code or stack traffic through the wrong base. In the unprotected mode the bench uses a top segment with a wrapping offset and two aliased pairs, and it issues a write and a request in the same cycle. A design that bypasses the new value into the request returns the new base rather than the old one.

// File: rtl/segx_pkg.sv
// Shared encodings for the segment translator.
// Assumes six architectural segments with fixed numbering.
package segx_pkg;
    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_FETCH = 2'd2,
        OP_RSVD  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_LIMIT = 2'd1,
        FLT_PERM  = 2'd2,
        FLT_INDEX = 2'd3
    } fault_e;

    localparam int SEG_COUNT = 6;
    localparam int SEG_ID_W  = 3;
    localparam logic [SEG_ID_W-1:0] SEG_CODE  = 3'd0;
    localparam logic [SEG_ID_W-1:0] SEG_STACK = 3'd1;
    localparam logic [SEG_ID_W-1:0] SEG_DATA  = 3'd2;
endpackage

// File: rtl/segx_select.sv
// Picks the segment register for an access.
// Priority: fetch -> code, stack -> stack, valid override -> named, else data.
// Assumes op codes from segx_pkg; purely combinational.
module segx_select
    import segx_pkg::*;
(
    input  logic [1:0]          op,
    input  logic                stack,
    input  logic                ovr_en,
    input  logic [SEG_ID_W-1:0] ovr_seg,
    output logic [SEG_ID_W-1:0] seg_id
);
    // Resolve implicit segment first, then the data override.
    always_comb begin
        if (op == OP_FETCH) begin
            seg_id = SEG_CODE;
        end else if (stack) begin
            seg_id = SEG_STACK;
        end else if (ovr_en && (ovr_seg < SEG_ID_W'(SEG_COUNT))) begin
            seg_id = ovr_seg;
        end else begin
            seg_id = SEG_DATA;
        end
    end
endmodule

// File: rtl/segx_regfile.sv
// Holds the segment registers and the descriptor table.
// One write port; two combinational read ports that show pre-write contents.
// Assumes IDX_W can address both the segments and the descriptors.
module segx_regfile
    import segx_pkg::*;
#(
    parameter int SEL_W  = 16,
    parameter int PA_W   = 32,
    parameter int OFF_W  = 32,
    parameter int DESC_N = 8,
    parameter int IDX_W  = 3,
    parameter int DW     = PA_W + OFF_W + 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                wr_sel,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [DW-1:0]       wr_data,
    input  logic [SEG_ID_W-1:0] rd_seg_id,
    output logic [SEL_W-1:0]    rd_sel,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [PA_W-1:0]     rd_base,
    output logic [OFF_W-1:0]    rd_limit,
    output logic                rd_r,
    output logic                rd_w,
    output logic                rd_x,
    output logic                rd_valid
);
    localparam int R_BIT = PA_W + OFF_W;
    localparam int W_BIT = R_BIT + 1;
    localparam int X_BIT = R_BIT + 2;
    localparam int V_BIT = R_BIT + 3;

    logic [SEG_COUNT-1:0][SEL_W-1:0] seg_a;
    logic [DESC_N-1:0][PA_W-1:0]     base_a;
    logic [DESC_N-1:0][OFF_W-1:0]    limit_a;
    logic [DESC_N-1:0][3:0]          attr_a;   // {valid, x, w, r}

    for (genvar s = 0; s < SEG_COUNT; s++) begin : g_seg
        logic [SEL_W-1:0] seg_q;

        // Load one segment register from the write port.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                seg_q <= '0;
            end else if (wr_en && !wr_sel && (wr_idx == IDX_W'(s))) begin
                seg_q <= wr_data[SEL_W-1:0];
            end
        end

        assign seg_a[s] = seg_q;

        assert_seg_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !wr_sel && (wr_idx == IDX_W'(s))) |=> (seg_q == $past(wr_data[SEL_W-1:0])));
    end

    for (genvar k = 0; k < DESC_N; k++) begin : g_desc
        logic [PA_W-1:0]  base_q;
        logic [OFF_W-1:0] limit_q;
        logic [3:0]       attr_q;

        // Load one descriptor entry; reset leaves it invalid.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q  <= '0;
                limit_q <= '0;
                attr_q  <= '0;
            end else if (wr_en && wr_sel && (wr_idx == IDX_W'(k))) begin
                base_q  <= wr_data[PA_W-1:0];
                limit_q <= wr_data[R_BIT-1:PA_W];
                attr_q  <= {wr_data[V_BIT], wr_data[X_BIT], wr_data[W_BIT], wr_data[R_BIT]};
            end
        end

        assign base_a[k]  = base_q;
        assign limit_a[k] = limit_q;
        assign attr_a[k]  = attr_q;

        assert_desc_valid_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_sel && (wr_idx == IDX_W'(k))) |=> (attr_q[3] == $past(wr_data[V_BIT])));
    end

    // Read the segment chosen by the selector logic.
    always_comb begin
        rd_sel = '0;
        for (int i = 0; i < SEG_COUNT; i++) begin
            if (rd_seg_id == SEG_ID_W'(i)) rd_sel = seg_a[i];
        end
    end

    // Read the descriptor named by the selector value.
    always_comb begin
        rd_base  = '0;
        rd_limit = '0;
        {rd_valid, rd_x, rd_w, rd_r} = 4'b0;
        for (int i = 0; i < DESC_N; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_base  = base_a[i];
                rd_limit = limit_a[i];
                {rd_valid, rd_x, rd_w, rd_r} = attr_a[i];
            end
        end
    end
endmodule

// File: rtl/segx_xlate.sv
// Forms the physical address and the fault code for one access.
// Unprotected: shifted segment value plus offset, no checks.
// Protected: index check, then limit, then rights, then base plus offset.
// Assumes the descriptor inputs belong to sel; combinational.
module segx_xlate
    import segx_pkg::*;
#(
    parameter int SEL_W  = 16,
    parameter int PA_W   = 32,
    parameter int OFF_W  = 32,
    parameter int DESC_N = 8,
    parameter int SHIFT  = 4
) (
    input  logic             prot_en,
    input  logic [1:0]       op,
    input  logic [SEL_W-1:0] sel,
    input  logic [OFF_W-1:0] offset,
    input  logic [PA_W-1:0]  base,
    input  logic [OFF_W-1:0] limit,
    input  logic             perm_r,
    input  logic             perm_w,
    input  logic             perm_x,
    input  logic             desc_valid,
    output logic [1:0]       fault,
    output logic [PA_W-1:0]  addr
);
    logic [PA_W-1:0] off_ext;
    logic [PA_W-1:0] real_base;
    logic            right_ok;
    logic            sel_in_range;

    assign off_ext      = PA_W'(offset);
    assign real_base    = PA_W'(sel) << SHIFT;
    assign sel_in_range = (32'(sel) < DESC_N);

    // Match the access type against the descriptor rights.
    always_comb begin
        unique case (op)
            OP_WRITE: right_ok = perm_w;
            OP_FETCH: right_ok = perm_x;
            default:  right_ok = perm_r;
        endcase
    end

    // Rank the faults and pick the address.
    always_comb begin
        fault = FLT_NONE;
        addr  = '0;
        if (!prot_en) begin
            addr = real_base + off_ext;
        end else if (!sel_in_range || !desc_valid) begin
            fault = FLT_INDEX;
        end else if (offset > limit) begin
            fault = FLT_LIMIT;
        end else if (!right_ok) begin
            fault = FLT_PERM;
        end else begin
            addr = base + off_ext;
        end
    end
endmodule

// File: rtl/segx_unit.sv
// Top of the segment translator: selection, tables, check and result register.
// The result appears one cycle after req_valid; idle cycles give zeros.
// Assumes a synchronous active-low reset and a single clock.
module segx_unit
    import segx_pkg::*;
#(
    parameter int SEL_W  = 16,
    parameter int PA_W   = 32,
    parameter int OFF_W  = 32,
    parameter int DESC_N = 8,
    parameter int SHIFT  = 4,
    parameter int IDX_W  = ($clog2(DESC_N) > SEG_ID_W) ? $clog2(DESC_N) : SEG_ID_W,
    parameter int DW     = PA_W + OFF_W + 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prot_en,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic             req_stack,
    input  logic             req_ovr_en,
    input  logic [2:0]       req_ovr_seg,
    input  logic [OFF_W-1:0] req_offset,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DW-1:0]    wr_data,
    output logic             rsp_valid,
    output logic [1:0]       rsp_fault,
    output logic [PA_W-1:0]  rsp_addr
);
    logic [SEG_ID_W-1:0] seg_id;
    logic [SEL_W-1:0]    sel;
    logic [PA_W-1:0]     d_base;
    logic [OFF_W-1:0]    d_limit;
    logic                d_r, d_w, d_x, d_valid;
    logic [1:0]          x_fault;
    logic [PA_W-1:0]     x_addr;

    segx_select u_select (
        .op      (req_op),
        .stack   (req_stack),
        .ovr_en  (req_ovr_en),
        .ovr_seg (req_ovr_seg),
        .seg_id  (seg_id)
    );

    segx_regfile #(
        .SEL_W (SEL_W), .PA_W (PA_W), .OFF_W (OFF_W),
        .DESC_N(DESC_N), .IDX_W (IDX_W), .DW (DW)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_seg_id (seg_id),
        .rd_sel    (sel),
        .rd_idx    (sel[IDX_W-1:0]),
        .rd_base   (d_base),
        .rd_limit  (d_limit),
        .rd_r      (d_r),
        .rd_w      (d_w),
        .rd_x      (d_x),
        .rd_valid  (d_valid)
    );

    segx_xlate #(
        .SEL_W (SEL_W), .PA_W (PA_W), .OFF_W (OFF_W),
        .DESC_N(DESC_N), .SHIFT (SHIFT)
    ) u_xlate (
        .prot_en    (prot_en),
        .op         (req_op),
        .sel        (sel),
        .offset     (req_offset),
        .base       (d_base),
        .limit      (d_limit),
        .perm_r     (d_r),
        .perm_w     (d_w),
        .perm_x     (d_x),
        .desc_valid (d_valid),
        .fault      (x_fault),
        .addr       (x_addr)
    );

    // Register the result; an idle cycle clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_fault <= FLT_NONE;
            rsp_addr  <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_fault <= req_valid ? x_fault : FLT_NONE;
            rsp_addr  <= req_valid ? x_addr  : '0;
        end
    end

    assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == ($past(req_valid) && $past(rst_n)));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> ((rsp_fault == FLT_NONE) && (rsp_addr == '0)));

    assert_unprotected_no_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(rst_n) && !$past(prot_en)) |-> (rsp_fault == FLT_NONE));

    assert_fault_blanks_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fault != FLT_NONE) |-> (rsp_addr == '0));
endmodule

// File: tb/segx_unit_test.sv
// Directed bench for segx_unit: one task per scenario, each checking its results.
module segx_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prot_en = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic        req_stack = 1'b0;
    logic        req_ovr_en = 1'b0;
    logic [2:0]  req_ovr_seg = 3'd0;
    logic [31:0] req_offset = '0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [2:0]  wr_idx = 3'd0;
    logic [67:0] wr_data = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_fault;
    logic [31:0] rsp_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench-side model of the table contents.
    logic [15:0] seg_m [6];
    logic [31:0] dbase [8];
    logic [31:0] dlim  [8];
    logic [3:0]  dattr [8];   // {valid, x, w, r}

    segx_unit uut (
        .clk(clk), .rst_n(rst_n), .prot_en(prot_en),
        .req_valid(req_valid), .req_op(req_op), .req_stack(req_stack),
        .req_ovr_en(req_ovr_en), .req_ovr_seg(req_ovr_seg), .req_offset(req_offset),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx), .wr_data(wr_data),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_addr(rsp_addr)
    );

    always #5 clk = ~clk;

    task automatic check(string rq, logic ev, logic [1:0] ef, logic [31:0] ea);
        checks++;
        if (rsp_valid !== ev || rsp_fault !== ef || rsp_addr !== ea) begin
            fails++;
            $display("FAIL %s: got valid=%0b fault=%0d addr=%h, expected valid=%0b fault=%0d addr=%h",
                     rq, rsp_valid, rsp_fault, rsp_addr, ev, ef, ea);
        end
    endtask

    task automatic seg_write(int idx, logic [15:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b0; wr_idx = 3'(idx); wr_data = {52'd0, v};
        seg_m[idx] = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic desc_write(int idx, logic [31:0] b, logic [31:0] l, logic [3:0] a);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b1; wr_idx = 3'(idx); wr_data = {a, l, b};
        dbase[idx] = b; dlim[idx] = l; dattr[idx] = a;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Expected result from the requirements.
    task automatic expect_of(logic [1:0] op, logic stk, logic oe, logic [2:0] os, logic [31:0] off,
                             output logic [1:0] f, output logic [31:0] a);
        int id;
        logic [15:0] s;
        logic ok;
        if (op == 2'd2) id = 0;
        else if (stk) id = 1;
        else if (oe && os < 3'd6) id = int'(os);
        else id = 2;
        s = seg_m[id];
        f = 2'd0; a = '0;
        if (!prot_en) begin
            a = ({16'd0, s} << 4) + off;
        end else if (s >= 16'd8 || !dattr[s[2:0]][3]) begin
            f = 2'd3;
        end else if (off > dlim[s[2:0]]) begin
            f = 2'd1;
        end else begin
            ok = (op == 2'd1) ? dattr[s[2:0]][1] : (op == 2'd2) ? dattr[s[2:0]][2] : dattr[s[2:0]][0];
            if (!ok) f = 2'd2;
            else a = dbase[s[2:0]] + off;
        end
    endtask

    task automatic access(string rq, logic [1:0] op, logic stk, logic oe, logic [2:0] os, logic [31:0] off);
        logic [1:0]  ef;
        logic [31:0] ea;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_stack = stk;
        req_ovr_en = oe; req_ovr_seg = os; req_offset = off;
        expect_of(op, stk, oe, os, off, ef, ea);
        @(negedge clk);
        req_valid = 1'b0; req_ovr_en = 1'b0; req_stack = 1'b0;
        check(rq, 1'b1, ef, ea);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 6; i++) seg_m[i] = '0;
        for (int i = 0; i < 8; i++) begin dbase[i] = '0; dlim[i] = '0; dattr[i] = '0; end
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 outputs in reset", 1'b0, 2'd0, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 outputs after reset", 1'b0, 2'd0, 32'd0);
        prot_en = 1'b1;
        access("R1 descriptors invalid after reset", 2'd0, 1'b0, 1'b0, 3'd0, 32'h0);
        prot_en = 1'b0;
    endtask

    task automatic t_unprotected();
        seg_write(0, 16'h1000); seg_write(1, 16'h2000); seg_write(2, 16'h3000);
        seg_write(3, 16'h4000); seg_write(4, 16'h5000); seg_write(5, 16'hFFFF);
        access("R3 R5 data read", 2'd0, 1'b0, 1'b0, 3'd0, 32'h10);
        check("R5 data read value", 1'b1, 2'd0, 32'h0003_0010);
        access("R3 fetch uses code", 2'd2, 1'b0, 1'b0, 3'd0, 32'h10);
        access("R3 stack push", 2'd1, 1'b1, 1'b0, 3'd0, 32'h20);
        access("R3 reserved op reads data", 2'd3, 1'b0, 1'b0, 3'd0, 32'h4);
        access("R4 override extra", 2'd0, 1'b0, 1'b1, 3'd3, 32'h10);
        access("R4 override free B", 2'd1, 1'b0, 1'b1, 3'd5, 32'h10);
        access("R4 override value 6 falls back", 2'd0, 1'b0, 1'b1, 3'd6, 32'h10);
        access("R4 override value 7 falls back", 2'd0, 1'b0, 1'b1, 3'd7, 32'h10);
        access("R4 override ignored on fetch", 2'd2, 1'b0, 1'b1, 3'd4, 32'h10);
        access("R4 override ignored on stack", 2'd0, 1'b1, 1'b1, 3'd4, 32'h10);
        access("R5 wrap modulo 2^32", 2'd0, 1'b0, 1'b1, 3'd5, 32'hFFFF_FFFF);
        check("R5 wrap value", 1'b1, 2'd0, 32'h000F_FFEF);
    endtask

    task automatic t_alias();
        seg_write(3, 16'h3001);
        access("R5 alias via extra", 2'd0, 1'b0, 1'b1, 3'd3, 32'h0);
        check("R5 alias equals data+0x10", 1'b1, 2'd0, 32'h0003_0010);
    endtask

    task automatic t_idle_and_same_cycle();
        @(negedge clk);
        check("R2 idle cycle quiet", 1'b0, 2'd0, 32'd0);
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd0; req_offset = 32'h8;
        wr_en = 1'b1; wr_sel = 1'b0; wr_idx = 3'd2; wr_data = {52'd0, 16'h7000};
        @(negedge clk);
        req_valid = 1'b0; wr_en = 1'b0;
        seg_m[2] = 16'h7000;
        check("R10 same-cycle request sees old segment", 1'b1, 2'd0, 32'h0003_0008);
        access("R10 new segment value applies", 2'd0, 1'b0, 1'b0, 3'd0, 32'h8);
        check("R10 new segment value", 1'b1, 2'd0, 32'h0007_0008);
        @(negedge clk);
        check("R2 no request after response", 1'b0, 2'd0, 32'd0);
    endtask

    task automatic t_protected();
        desc_write(0, 32'h0111_1000, 32'h01FF_FFFF, 4'b1111);
        desc_write(1, 32'h0000_8000, 32'h0000_00FF, 4'b1011);
        desc_write(2, 32'h0002_0000, 32'h0000_1000, 4'b1001);
        desc_write(3, 32'h0009_0000, 32'h0000_FFFF, 4'b0111);
        seg_write(0, 16'd0); seg_write(1, 16'd1); seg_write(2, 16'd2);
        seg_write(3, 16'd3); seg_write(4, 16'd9); seg_write(5, 16'd0);
        prot_en = 1'b1;
        access("R6 fetch translate", 2'd2, 1'b0, 1'b0, 3'd0, 32'h0123_4000);
        check("R6 fetch value", 1'b1, 2'd0, 32'h0234_5000);
        access("R7 offset equal limit", 2'd1, 1'b1, 1'b0, 3'd0, 32'hFF);
        check("R7 equal limit value", 1'b1, 2'd0, 32'h0000_80FF);
        access("R7 offset past limit", 2'd1, 1'b1, 1'b0, 3'd0, 32'h100);
        check("R7 past limit fault", 1'b1, 2'd1, 32'd0);
        access("R8 read allowed", 2'd0, 1'b0, 1'b0, 3'd0, 32'h1000);
        access("R8 write denied", 2'd1, 1'b0, 1'b0, 3'd0, 32'h10);
        check("R8 write denied code", 1'b1, 2'd2, 32'd0);
        access("R9 limit outranks permission", 2'd1, 1'b0, 1'b0, 3'd0, 32'h2000);
        check("R9 ranking value", 1'b1, 2'd1, 32'd0);
        access("R9 invalid entry", 2'd0, 1'b0, 1'b1, 3'd3, 32'h0);
        check("R9 invalid entry code", 1'b1, 2'd3, 32'd0);
        access("R9 selector past table", 2'd0, 1'b0, 1'b1, 3'd4, 32'h0);
        check("R9 selector past table code", 1'b1, 2'd3, 32'd0);
        access("R6 second selector aliases code", 2'd0, 1'b0, 1'b1, 3'd5, 32'h5);
        desc_write(0, 32'h0111_1000, 32'h01FF_FFFF, 4'b1011);
        access("R8 fetch without x", 2'd2, 1'b0, 1'b0, 3'd0, 32'h0);
        check("R8 fetch without x code", 1'b1, 2'd2, 32'd0);
        prot_en = 1'b0;
        access("R5 mode switch skips checks", 2'd0, 1'b0, 1'b1, 3'd4, 32'h3);
        check("R5 mode switch value", 1'b1, 2'd0, 32'h0000_0093);
    endtask

    initial begin
        t_reset();
        t_unprotected();
        t_alias();
        t_idle_and_same_cycle();
        t_protected();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: got no end of run, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule